// File: doc/BRIEF.md
# SECDED Check-Bit Generator and Fault Locator

This block protects a 64-bit word with eight check bits. The word arrives as an upper and a lower 32-bit half, together with the eight check bits read back from storage and a one-cycle strobe. Each check bit is the parity of a fixed subset of the data bits. The subsets come from a parity matrix that does not follow Hamming ordering. The block recomputes the check bits and XORs them with the received ones to form a syndrome. It then classifies the syndrome:

- **No error:** the syndrome is zero.
- **Single faulty data bit:** the syndrome equals the matrix column of one data bit. The data columns are searched first.
- **Single faulty check bit:** no data column matches and exactly one syndrome bit is set.
- **Uncorrectable:** anything else.

A located fault is corrected by flipping the bit concerned. All results are registered and appear one cycle after the strobe.

A two-state controller frames the results. In state `ST_WAIT` no fresh result is shown. In state `ST_SHOW` the outputs carry the result of the strobe taken on the previous edge. The transitions are:

- `WAIT_TO_SHOW`: a strobe while waiting.
- `SHOW_TO_SHOW`: a strobe while showing, so back-to-back strobes are accepted.
- `SHOW_TO_WAIT`: no strobe while showing.
- `WAIT_STAY`: no strobe while waiting.

Result registers hold their value until the next strobe.

Top module: `secded_check_unit`

## Requirements
- R1: `o_chk_calc` bit k equals the XOR of the data bits selected by mask pair k. Bit j of the high mask selects upper-half bit j, and bit j of the low mask selects lower-half bit j. The (high, low) pairs for k = 0..7 are:

  | k | high mask | low mask |
  |---|-----------|----------|
  | 0 | f00fe11e | c33c0ff7 |
  | 1 | 00ff00ff | 00fff0ff |
  | 2 | 0f0f0f0f | 0f0fff00 |
  | 3 | 11113333 | 7777000f |
  | 4 | 22224444 | 8888222f |
  | 5 | 44448888 | ffff4441 |
  | 6 | 8888ffff | 11118882 |
  | 7 | ffff1111 | 22221114 |

- R2: `o_syndrome` equals the computed check bits XOR the received check bits.
- R3: A zero syndrome raises no flag, reports index 127 (0x7F), and passes data and check bits through unchanged.
- R4: Data bit b is numbered 0..63 across {upper, lower}, with the lower half holding bits 0..31. Its column takes bit (b mod 32) of each mask: the high mask when b ≥ 32, the low mask otherwise. Mask pair k supplies column bit k. A syndrome equal to some data column is matched before any check-bit interpretation; the lowest matching b wins. On a match the block sets `o_sbe`, reports index b, flips data bit b, and leaves the check bits unchanged.
- R5: A syndrome that matches no data column and has exactly one bit set, bit k, identifies a faulty check bit. The block sets `o_cbe`, reports index 64+k, flips bit k of the received check bits on `o_chk_fixed`, and passes the data unchanged.
- R6: A syndrome that is nonzero, matches no data column and has two or more bits set is uncorrectable. The block sets `o_ue`, reports index 127, and passes data and check bits through unmodified.
- R7: The results of a strobe appear on the first clock edge after it, with `o_valid` high for exactly that cycle. Without a strobe, the result outputs keep their last values.
- R8: During and right after reset, `o_valid` and all flags are 0, the data, check and syndrome outputs are 0, and the index is 127.
- R9: At most one of `o_sbe`, `o_cbe`, `o_ue` is set at any time.
- R10: Strobes on consecutive cycles each produce their own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Word strobe |
| i_data_hi | input | 32 | Upper data half (bits 63..32) |
| i_data_lo | input | 32 | Lower data half (bits 31..0) |
| i_chk | input | 8 | Received check bits |
| o_valid | output | 1 | Fresh result this cycle |
| o_chk_calc | output | 8 | Check bits computed from the received data |
| o_syndrome | output | 8 | Computed XOR received check bits |
| o_data_hi | output | 32 | Corrected upper half |
| o_data_lo | output | 32 | Corrected lower half |
| o_chk_fixed | output | 8 | Corrected check bits |
| o_fault_idx | output | 7 | 0..63 data bit, 64..71 check bit, 127 none |
| o_sbe | output | 1 | Single data-bit error corrected |
| o_cbe | output | 1 | Single check-bit error corrected |
| o_ue | output | 1 | Uncorrectable error |

## Verification
Every result of this block is due exactly one clock edge after the strobe that carries its word. Nothing is due combinationally, and nothing is due later. The bench therefore drives a word on a falling edge and raises the strobe for one cycle. It reads all outputs on the next falling edge, which lies half a period after the single register stage has loaded. For the hold and back-to-back cases, the bench checks on the following falling edges that `o_valid` has dropped and the results are unchanged, or that each result belongs to its own strobe.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int HALF_W = 32;
    localparam int DATA_W = 2 * HALF_W;
    localparam int CHK_W  = 8;
    localparam int IDX_W  = $clog2(DATA_W + CHK_W);
    localparam logic [IDX_W-1:0] NO_IDX = '1;

    typedef enum logic [1:0] {
        FK_NONE,
        FK_DATA,
        FK_CHECK,
        FK_MULTI
    } fault_kind_t;

    // Parity mask over the upper half for check bit k
    function automatic logic [HALF_W-1:0] upper_mask(input int k);
        case (k)
            0: upper_mask = 32'hf00fe11e;
            1: upper_mask = 32'h00ff00ff;
            2: upper_mask = 32'h0f0f0f0f;
            3: upper_mask = 32'h11113333;
            4: upper_mask = 32'h22224444;
            5: upper_mask = 32'h44448888;
            6: upper_mask = 32'h8888ffff;
            default: upper_mask = 32'hffff1111;
        endcase
    endfunction

    // Parity mask over the lower half for check bit k
    function automatic logic [HALF_W-1:0] lower_mask(input int k);
        case (k)
            0: lower_mask = 32'hc33c0ff7;
            1: lower_mask = 32'h00fff0ff;
            2: lower_mask = 32'h0f0fff00;
            3: lower_mask = 32'h7777000f;
            4: lower_mask = 32'h8888222f;
            5: lower_mask = 32'hffff4441;
            6: lower_mask = 32'h11118882;
            default: lower_mask = 32'h22221114;
        endcase
    endfunction

    // Syndrome produced by a single flip of data bit b
    function automatic logic [CHK_W-1:0] data_column(input int b);
        logic [HALF_W-1:0] m;
        data_column = '0;
        for (int k = 0; k < CHK_W; k++) begin
            m = (b >= HALF_W) ? upper_mask(k) : lower_mask(k);
            data_column[k] = m[b % HALF_W];
        end
    endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [HALF_W-1:0] data_hi,
    input  logic [HALF_W-1:0] data_lo,
    output logic [CHK_W-1:0]  chk
);
    for (genvar k = 0; k < CHK_W; k++) begin : g_par
        localparam logic [HALF_W-1:0] MH = upper_mask(k);
        localparam logic [HALF_W-1:0] ML = lower_mask(k);
        assign chk[k] = (^(data_hi & MH)) ^ (^(data_lo & ML));
    end
endmodule

// File: rtl/secded_locator.sv
module secded_locator
    import secded_pkg::*;
(
    input  logic [CHK_W-1:0] syn,
    output fault_kind_t      kind,
    output logic [IDX_W-1:0] idx
);
    logic [DATA_W-1:0] hit;
    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  low_bit;

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        localparam logic [CHK_W-1:0] COL = data_column(b);
        assign hit[b] = (syn == COL);
    end

    // lowest matching data column
    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (hit[b]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(b);
            end
        end
    end

    // lowest set syndrome bit, only used when exactly one is set
    always_comb begin
        low_bit = '0;
        for (int k = CHK_W - 1; k >= 0; k--) begin
            if (syn[k]) low_bit = IDX_W'(DATA_W + k);
        end
    end

    always_comb begin
        if (syn == '0) begin
            kind = FK_NONE;
            idx  = NO_IDX;
        end else if (hit_any) begin
            kind = FK_DATA;
            idx  = hit_idx;
        end else if ($countones(syn) == 1) begin
            kind = FK_CHECK;
            idx  = low_bit;
        end else begin
            kind = FK_MULTI;
            idx  = NO_IDX;
        end
    end
endmodule

// File: rtl/secded_check_unit.sv
module secded_check_unit
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic [HALF_W-1:0] i_data_hi,
    input  logic [HALF_W-1:0] i_data_lo,
    input  logic [CHK_W-1:0]  i_chk,
    output logic              o_valid,
    output logic [CHK_W-1:0]  o_chk_calc,
    output logic [CHK_W-1:0]  o_syndrome,
    output logic [HALF_W-1:0] o_data_hi,
    output logic [HALF_W-1:0] o_data_lo,
    output logic [CHK_W-1:0]  o_chk_fixed,
    output logic [IDX_W-1:0]  o_fault_idx,
    output logic              o_sbe,
    output logic              o_cbe,
    output logic              o_ue
);
    typedef enum logic {ST_WAIT, ST_SHOW} state_t;
    state_t state, state_nx;

    logic [CHK_W-1:0]  calc;
    logic [CHK_W-1:0]  syn;
    fault_kind_t       kind;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word_in;
    logic [DATA_W-1:0] word_fix;
    logic [CHK_W-1:0]  chk_fix;

    secded_encoder u_enc (
        .data_hi (i_data_hi),
        .data_lo (i_data_lo),
        .chk     (calc)
    );

    assign syn = calc ^ i_chk;

    secded_locator u_loc (
        .syn  (syn),
        .kind (kind),
        .idx  (idx)
    );

    assign word_in = {i_data_hi, i_data_lo};

    always_comb begin
        word_fix = word_in;
        chk_fix  = i_chk;
        unique case (kind)
            FK_DATA:  word_fix = word_in ^ (DATA_W'(1) << idx[$clog2(DATA_W)-1:0]);
            FK_CHECK: chk_fix  = i_chk ^ (CHK_W'(1) << idx[$clog2(CHK_W)-1:0]);
            FK_NONE, FK_MULTI: ;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_WAIT: state_nx = i_valid ? ST_SHOW : ST_WAIT;
            ST_SHOW: state_nx = i_valid ? ST_SHOW : ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    assign o_valid = (state == ST_SHOW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_chk_calc  <= '0;
            o_syndrome  <= '0;
            o_data_hi   <= '0;
            o_data_lo   <= '0;
            o_chk_fixed <= '0;
            o_fault_idx <= NO_IDX;
            o_sbe       <= 1'b0;
            o_cbe       <= 1'b0;
            o_ue        <= 1'b0;
        end else if (i_valid) begin
            o_chk_calc  <= calc;
            o_syndrome  <= syn;
            {o_data_hi, o_data_lo} <= word_fix;
            o_chk_fixed <= chk_fix;
            o_fault_idx <= idx;
            o_sbe       <= (kind == FK_DATA);
            o_cbe       <= (kind == FK_CHECK);
            o_ue        <= (kind == FK_MULTI);
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_sbe, o_cbe, o_ue})); // R9
    AST_STROBE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> !o_valid); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> ($stable(o_data_hi) && $stable(o_data_lo) && $stable(o_fault_idx))); // R7
    AST_CLEAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (o_syndrome == '0) |-> (!o_sbe && !o_cbe && !o_ue && o_fault_idx == NO_IDX)); // R3
    AST_DATA_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        o_sbe |-> (o_fault_idx < IDX_W'(DATA_W) && o_chk_fixed == (o_chk_calc ^ o_syndrome))); // R4
    AST_CHECK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        o_cbe |-> ($countones(o_syndrome) == 1 && o_fault_idx >= IDX_W'(DATA_W))); // R5
    AST_UE_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        o_ue |-> ($countones(o_syndrome) > 1 && o_fault_idx == NO_IDX)); // R6
endmodule

// File: tb/test_secded_check_unit.sv
module test_secded_check_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [31:0] i_data_hi = '0;
    logic [31:0] i_data_lo = '0;
    logic [7:0]  i_chk = '0;
    logic        o_valid;
    logic [7:0]  o_chk_calc, o_syndrome, o_chk_fixed;
    logic [31:0] o_data_hi, o_data_lo;
    logic [6:0]  o_fault_idx;
    logic        o_sbe, o_cbe, o_ue;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    secded_check_unit i_secded_check_unit (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid),
        .i_data_hi(i_data_hi), .i_data_lo(i_data_lo), .i_chk(i_chk),
        .o_valid(o_valid), .o_chk_calc(o_chk_calc), .o_syndrome(o_syndrome),
        .o_data_hi(o_data_hi), .o_data_lo(o_data_lo), .o_chk_fixed(o_chk_fixed),
        .o_fault_idx(o_fault_idx), .o_sbe(o_sbe), .o_cbe(o_cbe), .o_ue(o_ue)
    );

    // requirement mask table (R1)
    function automatic logic [63:0] mpair(input int k);
        case (k)
            0: mpair = 64'hf00fe11e_c33c0ff7;
            1: mpair = 64'h00ff00ff_00fff0ff;
            2: mpair = 64'h0f0f0f0f_0f0fff00;
            3: mpair = 64'h11113333_7777000f;
            4: mpair = 64'h22224444_8888222f;
            5: mpair = 64'h44448888_ffff4441;
            6: mpair = 64'h8888ffff_11118882;
            default: mpair = 64'hffff1111_22221114;
        endcase
    endfunction

    function automatic logic [7:0] m_chk(input logic [63:0] w);
        logic [7:0] c = '0;
        for (int b = 0; b < 64; b++)
            for (int k = 0; k < 8; k++)
                if (w[b] && mpair(k)[b]) c[k] = ~c[k];
        return c;
    endfunction

    function automatic logic [7:0] m_col(input int b);
        logic [7:0] c = '0;
        for (int k = 0; k < 8; k++) c[k] = mpair(k)[b];
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one word, read the result one edge later, compare with the model
    task automatic apply(input logic [63:0] w, input logic [7:0] rc);
        logic [7:0]  e_calc, e_syn, e_chk;
        logic [63:0] e_data;
        logic [6:0]  e_idx;
        int          kind;
        int          cnt;
        @(negedge clk);
        i_data_hi = w[63:32]; i_data_lo = w[31:0]; i_chk = rc; i_valid = 1'b1;
        @(negedge clk);
        i_valid = 1'b0;
        e_calc = m_chk(w);
        e_syn  = e_calc ^ rc;
        e_data = w; e_chk = rc; e_idx = 7'h7f; kind = 0;
        if (e_syn != 0) begin
            kind = 3;
            for (int b = 63; b >= 0; b--) if (m_col(b) == e_syn) begin kind = 1; e_idx = 7'(b); end
            if (kind == 1) e_data = w ^ (64'd1 << e_idx);
            else begin
                cnt = 0;
                for (int k = 0; k < 8; k++) if (e_syn[k]) cnt++;
                if (cnt == 1) begin
                    kind = 2;
                    for (int k = 7; k >= 0; k--) if (e_syn[k]) e_idx = 7'(64 + k);
                    e_chk = rc ^ e_syn;
                end
            end
        end
        check(o_valid == 1'b1, "R7 valid", 64'(o_valid), 64'd1);
        check(o_chk_calc == e_calc, "R1 check bits", 64'(o_chk_calc), 64'(e_calc));
        check(o_syndrome == e_syn, "R2 syndrome", 64'(o_syndrome), 64'(e_syn));
        check({o_data_hi, o_data_lo} == e_data,
              kind == 1 ? "R4 data" : kind == 3 ? "R6 data" : kind == 2 ? "R5 data" : "R3 data",
              {o_data_hi, o_data_lo}, e_data);
        check(o_chk_fixed == e_chk, kind == 2 ? "R5 chk fixed" : "R3 R4 R6 chk fixed",
              64'(o_chk_fixed), 64'(e_chk));
        check(o_fault_idx == e_idx, "R4 R5 R6 index", 64'(o_fault_idx), 64'(e_idx));
        check({o_sbe, o_cbe, o_ue} == {kind == 1, kind == 2, kind == 3}, "R9 flags",
              64'({o_sbe, o_cbe, o_ue}), 64'({kind == 1, kind == 2, kind == 3}));
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(o_valid == 0 && o_sbe == 0 && o_cbe == 0 && o_ue == 0, "R8 flags",
              64'({o_valid, o_sbe, o_cbe, o_ue}), 64'd0);
        check({o_data_hi, o_data_lo, o_chk_calc, o_syndrome, o_chk_fixed} == '0, "R8 values",
              {o_data_hi, o_data_lo}, 64'd0);
        check(o_fault_idx == 7'h7f, "R8 index", 64'(o_fault_idx), 64'h7f);
        rst_n = 1'b1;
        @(negedge clk);
        check(o_valid == 0, "R8 after release", 64'(o_valid), 64'd0);
    endtask

    task automatic t_clean_words();
        logic [63:0] w;
        w = 64'h0; apply(w, m_chk(w));
        w = '1; apply(w, m_chk(w));
        w = 64'hdeadbeef_0123abcd; apply(w, m_chk(w));
        for (int b = 0; b < 64; b += 9) begin
            w = 64'd1 << b; apply(w, m_chk(w)); // R1 single-bit words
        end
    endtask

    task automatic t_data_bit_errors();
        logic [63:0] w;
        w = 64'ha5a5a5a5_5a5a5a5a;
        for (int b = 0; b < 64; b++) apply(w ^ (64'd1 << b), m_chk(w)); // R4
        w = 64'h13579bdf_2468ace0;
        for (int b = 0; b < 64; b += 5) apply(w ^ (64'd1 << b), m_chk(w)); // R4
    endtask

    task automatic t_check_bit_errors();
        logic [63:0] w;
        w = 64'hfeedface_cafef00d;
        for (int k = 0; k < 8; k++) apply(w, m_chk(w) ^ (8'd1 << k)); // R5
    endtask

    task automatic t_multi_errors();
        logic [63:0] w;
        w = 64'h0f1e2d3c_4b5a6978;
        for (int b = 0; b < 64; b += 3) apply(w ^ (64'd1 << b) ^ (64'd1 << ((b + 17) % 64)), m_chk(w)); // R6
        for (int k = 0; k < 7; k++) apply(w, m_chk(w) ^ (8'd3 << k)); // R6
        apply(w ^ 64'd1, m_chk(w) ^ 8'h80); // R6 data plus check
    endtask

    task automatic t_hold_and_stream();
        logic [63:0] w1, w2;
        logic [63:0] held;
        logic [6:0]  hidx;
        w1 = 64'h11112222_33334444;
        apply(w1 ^ (64'd1 << 40), m_chk(w1));
        held = {o_data_hi, o_data_lo}; hidx = o_fault_idx;
        i_data_hi = 32'h0; i_data_lo = 32'hffff; i_chk = 8'h55;
        @(negedge clk);
        check(o_valid == 0, "R7 valid drops", 64'(o_valid), 64'd0);
        check({o_data_hi, o_data_lo} == held && o_fault_idx == hidx, "R7 hold",
              {o_data_hi, o_data_lo}, held);
        // back-to-back strobes
        w2 = 64'h99998888_77776666;
        i_data_hi = w1[63:32]; i_data_lo = w1[31:0]; i_chk = m_chk(w1); i_valid = 1'b1;
        @(negedge clk);
        check(o_valid == 1 && {o_data_hi, o_data_lo} == w1 && o_fault_idx == 7'h7f,
              "R10 first", {o_data_hi, o_data_lo}, w1);
        i_data_hi = w2[63:32]; i_data_lo = w2[31:0] ^ 32'h8; i_chk = m_chk(w2);
        @(negedge clk);
        i_valid = 1'b0;
        check(o_valid == 1 && {o_data_hi, o_data_lo} == w2 && o_fault_idx == 7'd3 && o_sbe,
              "R10 second", {o_data_hi, o_data_lo}, w2);
        @(negedge clk);
        check(o_valid == 0, "R10 end", 64'(o_valid), 64'd0);
    endtask

    initial begin
        t_reset_state();
        t_clean_words();
        t_data_bit_errors();
        t_check_bit_errors();
        t_multi_errors();
        t_hold_and_stream();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule